// File: doc/BRIEF.md
# Configuration Address/Data Window Bridge

This bridge lets a processor reach the configuration registers of downstream devices through two tiny host windows. The selector window holds a 32-bit selector register. It carries an enable flag, a bus number, a device/function number and a register offset. The data window turns each host access into one downstream configuration request, built from the selector and from the byte lane of the access.

Before it forwards an access, the bridge gates it. The enable flag must be set. The selected function must be present, and it must not be hidden: a hot-added non-zero function is hidden when function 0 of its slot is absent. The offset must lie below the active space limit. Any access that fails one of these tests never leaves the bridge. A failed read returns all ones and a failed write is dropped. An access that passes has its length clipped so that it cannot cross the limit. It then goes out over a valid/ready request channel, and a read waits for its response strobe.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset the selector register is zero. A read of the selector window returns 0x00000000, and a data-window read returns 0xFFFFFFFF.
- R2: The selector register is loaded only by a write to the selector window with h_off = 0 and h_len = 4. Any other selector-window write leaves it unchanged.
- R3: A selector-window read returns all 32 bits of the selector register for any h_off and h_len. h_ack is high in the cycle after the request and carries the data in h_rdata.
- R4: While selector bit 31 is 0, a data-window read returns 0xFFFFFFFF and a data-window write issues no downstream request.
- R5: A forwarded request carries bus = selector[23:16] and devfn = selector[15:8]. Its offset is selector[7:0] ORed with h_off.
- R6: When d_present is low for the selected bus and devfn, a read returns 0xFFFFFFFF and a write is discarded.
- R7: When the offset is at or above the active limit, a read returns 0xFFFFFFFF and a write is discarded.
- R8: The forwarded d_len is the smaller of the requested length and the bytes left below the limit. A requested h_len of 0 or above 4 counts as 4.
- R9: When d_hotplug is high, devfn[2:0] is non-zero and d_fn0_present is low, the access behaves as if the function were absent.
- R10: The active limit is WIN_LIMIT when WIN_LIMIT <= STD_LIMIT or ext_space is high. Otherwise it is STD_LIMIT.
- R11: d_req_valid stays high with all request fields stable until d_req_ready. A write is acknowledged the cycle after the handshake. A read is acknowledged the cycle after d_rsp_valid, with h_rdata = d_rsp_data.
- R12: A host request arriving while h_busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access strobe, one cycle |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_sel | input | 1 | 0 = selector window, 1 = data window |
| h_off | input | 2 | Byte offset inside the window |
| h_len | input | 3 | Access length in bytes |
| h_wdata | input | 32 | Host write data |
| h_ack | output | 1 | Access complete, one-cycle pulse |
| h_rdata | output | 32 | Read data, valid with h_ack |
| h_busy | output | 1 | Data-window access in flight |
| ext_space | input | 1 | Bus supports the extended space limit |
| d_req_valid | output | 1 | Downstream request valid |
| d_req_ready | input | 1 | Downstream request accepted |
| d_req_wr | output | 1 | Downstream request is a write |
| d_bus | output | 8 | Selected bus number |
| d_devfn | output | 8 | Selected device/function |
| d_off | output | 8 | Register offset |
| d_len | output | 3 | Clipped byte length |
| d_wdata | output | 32 | Write data |
| d_rsp_valid | input | 1 | Read response strobe |
| d_rsp_data | input | 32 | Read response data |
| d_present | input | 1 | Selected function exists |
| d_hotplug | input | 1 | Selected function was hot-added |
| d_fn0_present | input | 1 | Function 0 of the selected slot exists |

## Verification
The bench drives two copies of the bridge side by side. One has the default limits. The other has a small standard limit and a larger window limit. Because both copies see the same host traffic, each offset near a boundary separates clipping from rejection, and setting ext_space separates the two limit values.

A behavioural target table supplies present functions, absent functions, a hidden hot-added function and a visible hot-added function. Each all-ones path is then reached by one gating test alone. The target echoes the bus, devfn, offset and length it received, so a wrong field or a wrong length shows up in the read data. Selector writes with the wrong offset, the wrong length, or sent while the bridge is busy confirm that the register stays untouched.

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge #(
  parameter int STD_LIMIT = 256,
  parameter int WIN_LIMIT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_req,
  input  logic        h_wr,
  input  logic        h_sel,
  input  logic [1:0]  h_off,
  input  logic [2:0]  h_len,
  input  logic [31:0] h_wdata,
  output logic        h_ack,
  output logic [31:0] h_rdata,
  output logic        h_busy,
  input  logic        ext_space,
  output logic        d_req_valid,
  input  logic        d_req_ready,
  output logic        d_req_wr,
  output logic [7:0]  d_bus,
  output logic [7:0]  d_devfn,
  output logic [7:0]  d_off,
  output logic [2:0]  d_len,
  output logic [31:0] d_wdata,
  input  logic        d_rsp_valid,
  input  logic [31:0] d_rsp_data,
  input  logic        d_present,
  input  logic        d_hotplug,
  input  logic        d_fn0_present
);
  localparam int LIM_MAX = (WIN_LIMIT > STD_LIMIT) ? WIN_LIMIT : STD_LIMIT;
  localparam int LIM_W = $clog2(LIM_MAX + 1) + 1;
  localparam logic [LIM_W-1:0] STD_L = LIM_W'(STD_LIMIT);
  localparam logic [LIM_W-1:0] WIN_L = LIM_W'(WIN_LIMIT);
  localparam bit NEEDS_EXT = (WIN_LIMIT > STD_LIMIT);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  state_t      state;
  logic [31:0] cfg_q;
  logic        wr_q;
  logic [7:0]  off_q;
  logic [2:0]  len_q;
  logic [31:0] wdata_q;

  logic [LIM_W-1:0] limit, off_x, room;
  logic [7:0] off_w;
  logic [2:0] len_req, len_fit;
  logic       hidden, in_range, pass, idle_req, sel_wr_ok;

  assign limit     = (NEEDS_EXT && !ext_space) ? STD_L : WIN_L;
  assign off_w     = cfg_q[7:0] | {6'd0, h_off};
  assign off_x     = LIM_W'(off_w);
  assign in_range  = off_x < limit;
  assign room      = limit - off_x;
  assign len_req   = (h_len == 3'd0 || h_len > 3'd4) ? 3'd4 : h_len;
  assign len_fit   = (room < LIM_W'(len_req)) ? room[2:0] : len_req;
  assign hidden    = d_hotplug && (cfg_q[10:8] != 3'd0) && !d_fn0_present;
  assign pass      = cfg_q[31] && d_present && !hidden && in_range;
  assign idle_req  = h_req && (state == S_IDLE);
  assign sel_wr_ok = (h_off == 2'd0) && (h_len == 3'd4);

  assign d_bus       = cfg_q[23:16];
  assign d_devfn     = cfg_q[15:8];
  assign d_off       = off_q;
  assign d_len       = len_q;
  assign d_req_wr    = wr_q;
  assign d_wdata     = wdata_q;
  assign d_req_valid = (state == S_ISSUE);
  assign h_busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cfg_q   <= '0;
      wr_q    <= 1'b0;
      off_q   <= '0;
      len_q   <= '0;
      wdata_q <= '0;
      h_ack   <= 1'b0;
      h_rdata <= '0;
    end else begin
      h_ack <= 1'b0;
      case (state)
        S_IDLE: if (idle_req) begin
          if (!h_sel) begin
            h_ack <= 1'b1;
            if (h_wr) begin
              if (sel_wr_ok) cfg_q <= h_wdata;
            end else begin
              h_rdata <= cfg_q;
            end
          end else if (pass) begin
            state   <= S_ISSUE;
            wr_q    <= h_wr;
            off_q   <= off_w;
            len_q   <= len_fit;
            wdata_q <= h_wdata;
          end else begin
            h_ack <= 1'b1;
            if (!h_wr) h_rdata <= '1;
          end
        end
        S_ISSUE: if (d_req_ready) begin
          if (wr_q) begin
            state <= S_IDLE;
            h_ack <= 1'b1;
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: if (d_rsp_valid) begin
          state   <= S_IDLE;
          h_rdata <= d_rsp_data;
          h_ack   <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_selector_only_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(h_req && h_wr && !h_sel && h_off == 2'd0 && h_len == 3'd4));

  a_r12_busy_keeps_selector: assert property (@(posedge clk) disable iff (!rst_n)
    h_busy |=> $stable(cfg_q));

  a_r11_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req_valid && !d_req_ready) |=>
      (d_req_valid && $stable({d_req_wr, d_bus, d_devfn, d_off, d_len, d_wdata})));

  a_r8_length_fits: assert property (@(posedge clk) disable iff (!rst_n)
    d_req_valid |-> (d_len != 3'd0 && d_len <= 3'd4 &&
                     (LIM_W'(d_off) + LIM_W'(d_len)) <= limit));

  a_r6_r9_gate_before_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d_req_valid) |-> $past(cfg_q[31] && d_present &&
                                 !(d_hotplug && d_devfn[2:0] != 3'd0 && !d_fn0_present)));

  a_r11_ack_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    h_ack |-> $past(h_req || h_busy));
endmodule

// File: tb/cfg_window_bridge_tb.sv
module cfg_target_stub (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  ready_delay,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_wr,
  input  logic [7:0]  bus,
  input  logic [7:0]  devfn,
  input  logic [7:0]  off,
  input  logic [2:0]  len,
  input  logic [31:0] wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        present,
  output logic        hotplug,
  output logic        fn0,
  output logic [15:0] wr_count,
  output logic [31:0] last_wdata,
  output logic [7:0]  last_off,
  output logic [2:0]  last_len
);
  logic [3:0] wcnt;
  logic       pend;
  logic [31:0] pend_data;

  function automatic logic exists(input logic [7:0] b, input logic [7:0] df);
    return (b == 8'd0 && (df == 8'h08 || df == 8'h09 || df == 8'h12 ||
                          df == 8'h18 || df == 8'h1A)) ||
           (b == 8'd1 && df == 8'h00);
  endfunction

  assign present   = exists(bus, devfn);
  assign fn0       = exists(bus, {devfn[7:3], 3'b000});
  assign hotplug   = (bus == 8'd0) && (devfn[7:3] == 5'd2 || devfn[7:3] == 5'd3);
  assign req_ready = req_valid && (wcnt >= ready_delay);

  always @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0; pend <= 1'b0; pend_data <= '0; rsp_valid <= 1'b0; rsp_data <= '0;
      wr_count <= '0; last_wdata <= '0; last_off <= '0; last_len <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (pend) begin
        rsp_valid <= 1'b1;
        rsp_data  <= pend_data;
        pend      <= 1'b0;
      end
      if (req_valid && req_ready) begin
        wcnt <= '0;
        if (req_wr) begin
          wr_count   <= wr_count + 16'd1;
          last_wdata <= wdata;
          last_off   <= off;
          last_len   <= len;
        end else begin
          pend      <= 1'b1;
          pend_data <= {bus, devfn, off, 5'd0, len};
        end
      end else if (req_valid) begin
        wcnt <= wcnt + 4'd1;
      end
    end
  end
endmodule

module cfg_window_bridge_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        h_req = 0, h_wr = 0, h_sel = 0, ext_space = 0;
  logic [1:0]  h_off = 0;
  logic [2:0]  h_len = 0;
  logic [31:0] h_wdata = 0;
  logic [3:0]  ready_delay = 0;

  logic        ack_a, busy_a, dv_a, dr_a, dw_a, rv_a, pr_a, hp_a, f0_a;
  logic [31:0] rd_a, dwd_a, rsp_a, lwd_a;
  logic [7:0]  db_a, ddf_a, doff_a, loff_a;
  logic [2:0]  dl_a, ll_a;
  logic [15:0] wc_a;

  logic        ack_b, busy_b, dv_b, dr_b, dw_b, rv_b, pr_b, hp_b, f0_b;
  logic [31:0] rd_b, dwd_b, rsp_b, lwd_b;
  logic [7:0]  db_b, ddf_b, doff_b, loff_b;
  logic [2:0]  dl_b, ll_b;
  logic [15:0] wc_b;

  cfg_window_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_wr(h_wr), .h_sel(h_sel), .h_off(h_off),
    .h_len(h_len), .h_wdata(h_wdata), .h_ack(ack_a), .h_rdata(rd_a), .h_busy(busy_a),
    .ext_space(ext_space), .d_req_valid(dv_a), .d_req_ready(dr_a), .d_req_wr(dw_a),
    .d_bus(db_a), .d_devfn(ddf_a), .d_off(doff_a), .d_len(dl_a), .d_wdata(dwd_a),
    .d_rsp_valid(rv_a), .d_rsp_data(rsp_a), .d_present(pr_a), .d_hotplug(hp_a),
    .d_fn0_present(f0_a));

  cfg_window_bridge #(.STD_LIMIT(64), .WIN_LIMIT(128)) u_dut_lim (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_wr(h_wr), .h_sel(h_sel), .h_off(h_off),
    .h_len(h_len), .h_wdata(h_wdata), .h_ack(ack_b), .h_rdata(rd_b), .h_busy(busy_b),
    .ext_space(ext_space), .d_req_valid(dv_b), .d_req_ready(dr_b), .d_req_wr(dw_b),
    .d_bus(db_b), .d_devfn(ddf_b), .d_off(doff_b), .d_len(dl_b), .d_wdata(dwd_b),
    .d_rsp_valid(rv_b), .d_rsp_data(rsp_b), .d_present(pr_b), .d_hotplug(hp_b),
    .d_fn0_present(f0_b));

  cfg_target_stub u_tgt_a (
    .clk(clk), .rst_n(rst_n), .ready_delay(ready_delay), .req_valid(dv_a), .req_ready(dr_a),
    .req_wr(dw_a), .bus(db_a), .devfn(ddf_a), .off(doff_a), .len(dl_a), .wdata(dwd_a),
    .rsp_valid(rv_a), .rsp_data(rsp_a), .present(pr_a), .hotplug(hp_a), .fn0(f0_a),
    .wr_count(wc_a), .last_wdata(lwd_a), .last_off(loff_a), .last_len(ll_a));

  cfg_target_stub u_tgt_b (
    .clk(clk), .rst_n(rst_n), .ready_delay(ready_delay), .req_valid(dv_b), .req_ready(dr_b),
    .req_wr(dw_b), .bus(db_b), .devfn(ddf_b), .off(doff_b), .len(dl_b), .wdata(dwd_b),
    .rsp_valid(rv_b), .rsp_data(rsp_b), .present(pr_b), .hotplug(hp_b), .fn0(f0_b),
    .wr_count(wc_b), .last_wdata(lwd_b), .last_off(loff_b), .last_len(ll_b));

  int checks = 0;
  int errors = 0;
  logic [31:0] ra, rb;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  function automatic logic [31:0] sel(input logic en, input logic [7:0] b,
                                      input logic [7:0] df, input logic [7:0] o);
    return {en, 7'd0, b, df, o};
  endfunction

  function automatic logic [31:0] echo(input logic [7:0] b, input logic [7:0] df,
                                       input logic [7:0] o, input logic [2:0] l);
    return {b, df, o, 5'd0, l};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic s, input logic w, input logic [1:0] o,
                        input logic [2:0] l, input logic [31:0] d);
    logic ga, gb;
    ga = 0; gb = 0;
    @(negedge clk);
    h_req = 1; h_sel = s; h_wr = w; h_off = o; h_len = l; h_wdata = d;
    @(negedge clk);
    h_req = 0;
    for (int i = 0; i < 64 && !(ga && gb); i++) begin
      if (ack_a && !ga) begin ga = 1; ra = rd_a; end
      if (ack_b && !gb) begin gb = 1; rb = rd_b; end
      if (!(ga && gb)) @(negedge clk);
    end
    if (!(ga && gb)) begin
      checks++; errors++;
      $display("FAIL R11 no acknowledge actual=%b%b expected=11", ga, gb);
    end
  endtask

  task automatic set_sel(input logic [31:0] v);
    access(0, 1, 2'd0, 3'd4, v);
  endtask

  task automatic t_reset;
    access(0, 0, 2'd0, 3'd4, 0);
    check("R1 selector after reset (main)", ra, 32'h0);
    check("R1 selector after reset (lim)", rb, 32'h0);
    access(1, 0, 2'd0, 3'd4, 0);
    check("R1 data read after reset", ra, ONES);
  endtask

  task automatic t_selector;
    set_sel(32'h8000_0810);
    access(0, 0, 2'd0, 3'd4, 0);
    check("R2 aligned selector write", ra, 32'h8000_0810);
    access(0, 1, 2'd1, 3'd4, 32'h1234_5678);
    access(0, 0, 2'd0, 3'd4, 0);
    check("R2 offset-1 write ignored", ra, 32'h8000_0810);
    access(0, 1, 2'd0, 3'd2, 32'h0000_5678);
    access(0, 0, 2'd0, 3'd4, 0);
    check("R2 short write ignored", ra, 32'h8000_0810);
    access(0, 0, 2'd2, 3'd1, 0);
    check("R3 read at offset 2 len 1 returns full", ra, 32'h8000_0810);
  endtask

  task automatic t_disabled;
    logic [15:0] c0;
    set_sel(sel(0, 8'd0, 8'h08, 8'h10));
    access(1, 0, 2'd0, 3'd4, 0);
    check("R4 disabled read", ra, ONES);
    c0 = wc_a;
    access(1, 1, 2'd0, 3'd4, 32'hCAFE_0001);
    check("R4 disabled write dropped", {16'd0, wc_a}, {16'd0, c0});
  endtask

  task automatic t_forward;
    logic [15:0] c0;
    ready_delay = 4'd3;
    set_sel(sel(1, 8'd0, 8'h08, 8'h10));
    access(1, 0, 2'd2, 3'd2, 0);
    check("R5 R11 read fields (main)", ra, echo(8'd0, 8'h08, 8'h12, 3'd2));
    check("R5 R11 read fields (lim)", rb, echo(8'd0, 8'h08, 8'h12, 3'd2));
    c0 = wc_a;
    access(1, 1, 2'd1, 3'd1, 32'h0000_00A5);
    check("R11 write forwarded", {16'd0, wc_a}, {16'd0, c0 + 16'd1});
    check("R5 write offset", {24'd0, loff_a}, 32'h11);
    check("R5 write data", lwd_a, 32'h0000_00A5);
    check("R8 write length", {29'd0, ll_a}, 32'd1);
    ready_delay = 4'd0;
    set_sel(sel(1, 8'd1, 8'h00, 8'h00));
    access(1, 0, 2'd0, 3'd4, 0);
    check("R5 bus 1 read", ra, echo(8'd1, 8'h00, 8'h00, 3'd4));
    set_sel(sel(1, 8'd0, 8'h08, 8'h10));
    access(1, 0, 2'd0, 3'd7, 0);
    check("R8 length 7 counts as 4", ra, echo(8'd0, 8'h08, 8'h10, 3'd4));
  endtask

  task automatic t_absent;
    logic [15:0] c0;
    set_sel(sel(1, 8'd0, 8'h20, 8'h00));
    access(1, 0, 2'd0, 3'd4, 0);
    check("R6 absent read", ra, ONES);
    c0 = wc_a;
    access(1, 1, 2'd0, 3'd4, 32'h1);
    check("R6 absent write dropped", {16'd0, wc_a}, {16'd0, c0});
  endtask

  task automatic t_hidden;
    logic [15:0] c0;
    set_sel(sel(1, 8'd0, 8'h12, 8'h10));
    access(1, 0, 2'd0, 3'd4, 0);
    check("R9 hidden function read", ra, ONES);
    c0 = wc_a;
    access(1, 1, 2'd0, 3'd4, 32'h2);
    check("R9 hidden function write dropped", {16'd0, wc_a}, {16'd0, c0});
    set_sel(sel(1, 8'd0, 8'h1A, 8'h10));
    access(1, 0, 2'd0, 3'd4, 0);
    check("R9 hot-added with fn0 visible", ra, echo(8'd0, 8'h1A, 8'h10, 3'd4));
  endtask

  task automatic t_limits;
    logic [15:0] c0, c1;
    ext_space = 0;
    set_sel(sel(1, 8'd0, 8'h08, 8'hFC));
    access(1, 0, 2'd3, 3'd4, 0);
    check("R8 clip at 256 (main)", ra, echo(8'd0, 8'h08, 8'hFF, 3'd1));
    check("R7 beyond 64 (lim)", rb, ONES);
    set_sel(sel(1, 8'd0, 8'h08, 8'h3C));
    access(1, 0, 2'd2, 3'd4, 0);
    check("R8 clip at 64 (lim)", rb, echo(8'd0, 8'h08, 8'h3E, 3'd2));
    check("R8 no clip (main)", ra, echo(8'd0, 8'h08, 8'h3E, 3'd4));
    set_sel(sel(1, 8'd0, 8'h08, 8'h40));
    access(1, 0, 2'd0, 3'd4, 0);
    check("R7 R10 at limit 64 without ext (lim)", rb, ONES);
    ext_space = 1;
    access(1, 0, 2'd0, 3'd4, 0);
    check("R10 ext raises limit (lim)", rb, echo(8'd0, 8'h08, 8'h40, 3'd4));
    set_sel(sel(1, 8'd0, 8'h08, 8'h7C));
    access(1, 0, 2'd2, 3'd3, 0);
    check("R8 R10 clip at 128 (lim)", rb, echo(8'd0, 8'h08, 8'h7E, 3'd2));
    check("R8 len 3 (main)", ra, echo(8'd0, 8'h08, 8'h7E, 3'd3));
    set_sel(sel(1, 8'd0, 8'h08, 8'h80));
    c0 = wc_a; c1 = wc_b;
    access(1, 1, 2'd0, 3'd4, 32'h3);
    check("R7 write at 128 dropped (lim)", {16'd0, wc_b}, {16'd0, c1});
    check("R7 write below 256 kept (main)", {16'd0, wc_a}, {16'd0, c0 + 16'd1});
    ext_space = 0;
  endtask

  task automatic t_busy;
    ready_delay = 4'd6;
    set_sel(sel(1, 8'd0, 8'h09, 8'h20));
    @(negedge clk);
    h_req = 1; h_sel = 1; h_wr = 0; h_off = 2'd0; h_len = 3'd4;
    @(negedge clk);
    h_sel = 0; h_wr = 1; h_wdata = 32'h8000_0000;
    @(negedge clk);
    h_req = 0;
    for (int i = 0; i < 64 && !ack_a; i++) @(negedge clk);
    check("R11 stalled read data", rd_a, echo(8'd0, 8'h09, 8'h20, 3'd4));
    ready_delay = 4'd0;
    access(0, 0, 2'd0, 3'd4, 0);
    check("R12 selector write while busy ignored", ra, sel(1, 8'd0, 8'h09, 8'h20));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_selector;
    t_disabled;
    t_forward;
    t_absent;
    t_hidden;
    t_limits;
    t_busy;
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule